// File: doc/BRIEF.md
# Processor Trace Status Encoder

This block reports what a processor core is doing, one clock at a time, on two 4-bit output ports. The status port carries a code for the event that wins priority in the cycle. The data port streams operand or address bytes, one nibble per clock, after the status port has announced a data transfer.

The core drives level-sensitive event inputs every cycle:
- instruction retire
- return-from-exception
- operand-data capture, with a byte-count select and a 32-bit value
- normal exception processing
- emulator-mode exception processing
- stopped
- halted

Multicycle states, such as exception processing, stop and halt, are held on the status port for as long as the core keeps the matching input high. Captured bytes go into an 8-nibble FIFO, so later instructions can keep reporting while earlier data drains. When a capture does not fit into the free FIFO space, the block raises a stall request back to the pipeline for that cycle.

Top module: `trace_status_encoder`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, `pst`, `ddata` and `stall` are all 0, and the FIFO is empty.
- R2: `pst` is registered: it shows the code for the inputs sampled at the previous rising edge. A retire shows 0x1, a return-from-exception shows 0x7, and a cycle with no event shows 0x0.
- R3: An accepted capture shows a code on `pst` that depends on `dataSize`: select 0 shows 0x8 (1 byte), select 1 shows 0x9 (2 bytes), and select 2 or 3 shows 0xA (4 bytes).
- R4: Captured bytes leave on `ddata` one nibble per clock, least significant nibble of `dataValue` first, two nibbles per byte. When the FIFO is empty at capture, the first nibble appears exactly one clock after the code appears on `pst`.
- R5: A capture is accepted only if the FIFO's free space at the start of the cycle (8 minus the nibbles held) covers all of its nibbles. Otherwise, within the same cycle, `stall` is 1, nothing is queued, and on the next clock `pst` shows 0x0.
- R6: `ddata` shows 0x0 in any cycle in which no queued nibble is being output.
- R7: Normal exception processing shows 0xC and emulator-mode exception processing shows 0xD. Each code is repeated every cycle for as long as its input is held high.
- R8: The stopped state shows 0xE and the halted state shows 0xF, each for every cycle its input is held high.
- R9: When several events occur in one cycle, the code shown is chosen in this priority order: halt, stop, emulator exception, exception, capture, return-from-exception, retire. `stall` is raised only when the capture is the winning event.
- R10: Queued nibbles keep draining on `ddata` while `pst` reports later events, unchanged in order and value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| retireEv | input | 1 | An instruction retires this cycle |
| rteEv | input | 1 | A return-from-exception executes this cycle |
| captureEv | input | 1 | Operand or address data to be reported this cycle |
| dataSize | input | 2 | Byte-count select: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| dataValue | input | 32 | Captured value, low bytes used first |
| excEv | input | 1 | Normal exception processing is in progress |
| emuExcEv | input | 1 | Emulator-mode exception processing is in progress |
| stopEv | input | 1 | Core is stopped |
| haltEv | input | 1 | Core is halted |
| pst | output | 4 | Processor status code |
| ddata | output | 4 | Debug data nibble, 0 when idle |
| stall | output | 1 | Pipeline stall request, combinational |

## Verification
The embedded assertions check several properties on every cycle:
- the FIFO never holds more than its depth;
- a stall never pushes data, and it is followed by a zero status code;
- an empty FIFO yields a zero data nibble;
- halt always wins;
- emulator-mode exceptions outrank normal exceptions.

Other behaviour can only be shown by the bench's reference model, which compares all three outputs on every clock:
- the exact code for each byte count;
- the one-clock gap between the announcement and the first nibble;
- least-significant-nibble-first ordering;
- draining under later events;
- the exact free-space boundary at which a 4-byte capture is refused.

// File: rtl/tse_pkg.sv
package tse_pkg;

  typedef enum logic [3:0] {
    PST_IDLE   = 4'h0,
    PST_RETIRE = 4'h1,
    PST_RTE    = 4'h7,
    PST_DATA1  = 4'h8,
    PST_DATA2  = 4'h9,
    PST_DATA4  = 4'hA,
    PST_EXC    = 4'hC,
    PST_EMU    = 4'hD,
    PST_STOP   = 4'hE,
    PST_HALT   = 4'hF
  } pst_code_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       pushEn;
    logic [7:0] pushNibbles;
  } fifo_ctrl_t;

endpackage

// File: rtl/tse_datapath.sv
module tse_datapath
  import tse_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  fifo_ctrl_t                     ctrl,
  input  logic [DATA_W-1:0]              dataValue,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic [3:0]                     ddata
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int MAXN  = DATA_W / 4;

  logic [3:0]       mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic             popEn;
  logic [CNT_W-1:0] pushCnt, popCnt;

  assign popEn   = (count != '0);
  assign pushCnt = ctrl.pushEn ? CNT_W'(ctrl.pushNibbles) : '0;
  assign popCnt  = popEn ? CNT_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
      ddata <= 4'h0;
    end else begin
      ddata <= popEn ? mem[rdPtr] : 4'h0;
      if (popEn) rdPtr <= rdPtr + PTR_W'(1);
      if (ctrl.pushEn) wrPtr <= wrPtr + PTR_W'(ctrl.pushNibbles);
      count <= count + pushCnt - popCnt;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < MAXN; i++) begin
      if (ctrl.pushEn && (i < int'(ctrl.pushNibbles)))
        mem[wrPtr + PTR_W'(i)] <= dataValue[4*i +: 4];
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0) |=> (ddata == 4'h0));

endmodule

// File: rtl/tse_control.sv
module tse_control
  import tse_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        retireEv,
  input  logic                        rteEv,
  input  logic                        captureEv,
  input  logic [1:0]                  dataSize,
  input  logic                        excEv,
  input  logic                        emuExcEv,
  input  logic                        stopEv,
  input  logic                        haltEv,
  input  logic [$clog2(DEPTH+1)-1:0]  count,
  output logic [3:0]                  pst,
  output logic                        stall,
  output fifo_ctrl_t                  ctrl
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [7:0]       needNib;
  logic [CNT_W:0]   freeNib;
  logic             fits;
  pst_code_t        nextCode;
  pst_code_t        dataCode;

  always_comb begin
    unique case (dataSize)
      2'd0:    begin needNib = 8'd2; dataCode = PST_DATA1; end
      2'd1:    begin needNib = 8'd4; dataCode = PST_DATA2; end
      default: begin needNib = 8'd8; dataCode = PST_DATA4; end
    endcase
  end

  assign freeNib = (CNT_W+1)'(DEPTH) - (CNT_W+1)'(count);
  assign fits    = ({24'd0, needNib} <= 32'(freeNib));

  always_comb begin
    nextCode         = PST_IDLE;
    stall            = 1'b0;
    ctrl.pushEn      = 1'b0;
    ctrl.pushNibbles = needNib;
    if (haltEv)        nextCode = PST_HALT;
    else if (stopEv)   nextCode = PST_STOP;
    else if (emuExcEv) nextCode = PST_EMU;
    else if (excEv)    nextCode = PST_EXC;
    else if (captureEv) begin
      if (fits) begin
        nextCode    = dataCode;
        ctrl.pushEn = 1'b1;
      end else begin
        stall = 1'b1;
      end
    end
    else if (rteEv)    nextCode = PST_RTE;
    else if (retireEv) nextCode = PST_RETIRE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pst <= 4'h0;
    else       pst <= nextCode;
  end

  assert_stall_blank_R5: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (pst == 4'h0));

  assert_stall_no_push_R5: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !ctrl.pushEn);

  assert_halt_first_R9: assert property (@(posedge clk) disable iff (!rstN)
    haltEv |=> (pst == 4'hF));

  assert_emu_over_exc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (emuExcEv && !haltEv && !stopEv) |=> (pst == 4'hD));

endmodule

// File: rtl/trace_status_encoder.sv
module trace_status_encoder
  import tse_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retireEv,
  input  logic              rteEv,
  input  logic              captureEv,
  input  logic [1:0]        dataSize,
  input  logic [DATA_W-1:0] dataValue,
  input  logic              excEv,
  input  logic              emuExcEv,
  input  logic              stopEv,
  input  logic              haltEv,
  output logic [3:0]        pst,
  output logic [3:0]        ddata,
  output logic              stall
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  fifo_ctrl_t       ctrl;
  logic [CNT_W-1:0] count;

  tse_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .retireEv(retireEv), .rteEv(rteEv),
    .captureEv(captureEv), .dataSize(dataSize), .excEv(excEv),
    .emuExcEv(emuExcEv), .stopEv(stopEv), .haltEv(haltEv),
    .count(count), .pst(pst), .stall(stall), .ctrl(ctrl)
  );

  tse_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .dataValue(dataValue),
    .count(count), .ddata(ddata)
  );

endmodule

// File: tb/trace_status_encoder_test.sv
module trace_status_encoder_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic retireEv = 0, rteEv = 0, captureEv = 0, excEv = 0, emuExcEv = 0;
  logic stopEv = 0, haltEv = 0;
  logic [1:0]  dataSize = 0;
  logic [31:0] dataValue = 0;
  logic [3:0]  pst, ddata;
  logic        stall;

  int checks = 0, fails = 0;
  int q[$];
  int expPst = 0, expDd = 0;

  always #2 clk = ~clk;

  trace_status_encoder uut (
    .clk(clk), .rstN(rstN), .retireEv(retireEv), .rteEv(rteEv),
    .captureEv(captureEv), .dataSize(dataSize), .dataValue(dataValue),
    .excEv(excEv), .emuExcEv(emuExcEv), .stopEv(stopEv), .haltEv(haltEv),
    .pst(pst), .ddata(ddata), .stall(stall)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int nibs(logic [1:0] s);
    return (s == 0) ? 2 : (s == 1) ? 4 : 8;
  endfunction

  function automatic int nEvents();
    return int'(haltEv) + int'(stopEv) + int'(emuExcEv) + int'(excEv)
         + int'(captureEv) + int'(rteEv) + int'(retireEv);
  endfunction

  function automatic bit dataWins();
    return captureEv && !haltEv && !stopEv && !emuExcEv && !excEv;
  endfunction

  function automatic bit expStall();
    return dataWins() && (nibs(dataSize) > 8 - q.size());
  endfunction

  // One clock: inputs already driven after the falling edge
  task automatic cycle();
    string pTag, dTag;
    bit hadData;
    #1;
    check(nEvents() > 1 ? "R9 stall" : "R5 stall", int'(stall), int'(expStall()));
    pTag = nEvents() > 1 ? "R9" : haltEv || stopEv ? "R8" :
           (emuExcEv || excEv) ? "R7" : captureEv ? (expStall() ? "R5" : "R3") : "R2";
    hadData = q.size() > 0;
    @(posedge clk);
    if (q.size() > 0) expDd = q.pop_front(); else expDd = 0;
    if (haltEv) expPst = 'hF;
    else if (stopEv) expPst = 'hE;
    else if (emuExcEv) expPst = 'hD;
    else if (excEv) expPst = 'hC;
    else if (captureEv) begin
      if (nibs(dataSize) <= 8 - (q.size() + (hadData ? 1 : 0))) begin
        expPst = (dataSize == 0) ? 8 : (dataSize == 1) ? 9 : 'hA;
        for (int i = 0; i < nibs(dataSize); i++) q.push_back(int'(dataValue[4*i +: 4]));
      end else expPst = 0;
    end
    else if (rteEv) expPst = 7;
    else if (retireEv) expPst = 1;
    else expPst = 0;
    #1;
    dTag = !hadData ? "R6" : (expPst >= 8 && expPst <= 'hA) ? "R4" : "R10";
    check(pTag, int'(pst), expPst);
    check(dTag, int'(ddata), expDd);
    @(negedge clk);
  endtask

  task automatic ev(bit h, bit s, bit em, bit ex, bit cap, logic [1:0] sz,
                    logic [31:0] v, bit rt, bit rr);
    haltEv = h; stopEv = s; emuExcEv = em; excEv = ex; captureEv = cap;
    dataSize = sz; dataValue = v; rteEv = rt; retireEv = rr;
    cycle();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) ev(0,0,0,0,0,0,0,0,0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pst", int'(pst), 0);
    check("R1 ddata", int'(ddata), 0);
    check("R1 stall", int'(stall), 0);
    rstN = 1'b1;
    idle(1);
    // R2 basic codes
    ev(0,0,0,0,0,0,0,0,1);
    ev(0,0,0,0,0,0,0,1,0);
    idle(1);
    // R3 R4: each size, from empty, LSB nibble first
    ev(0,0,0,0,1,0,32'h0000_00A5,0,0);
    idle(3);
    ev(0,0,0,0,1,1,32'h0000_C3B2,0,0);
    idle(5);
    ev(0,0,0,0,1,2,32'h8765_4321,0,0);
    idle(9);
    ev(0,0,0,0,1,3,32'h1357_9BDF,0,0);
    // R5: full FIFO refuses a 1-byte capture, stall held
    ev(0,0,0,0,1,0,32'h11,0,0);
    ev(0,0,0,0,1,0,32'h22,0,0);
    // R10: later events while draining
    ev(0,0,0,0,0,0,0,0,1);
    ev(0,0,0,0,0,0,0,1,0);
    idle(6);
    // R5 boundary: 2 nibbles queued, 4-byte refused, 2-byte accepted
    ev(0,0,0,0,1,0,32'h5A,0,0);
    ev(0,0,0,0,1,2,32'hFEDC_BA98,0,0);
    ev(0,0,0,0,1,1,32'h6789,0,0);
    idle(8);
    // R7 R8 held states
    for (int i = 0; i < 3; i++) ev(0,0,0,1,0,0,0,0,0);
    for (int i = 0; i < 3; i++) ev(0,0,1,0,0,0,0,0,0);
    for (int i = 0; i < 3; i++) ev(0,1,0,0,0,0,0,0,0);
    for (int i = 0; i < 3; i++) ev(1,0,0,0,0,0,0,0,0);
    // R9 priority combinations
    ev(1,1,1,1,1,2,32'hFFFF_FFFF,1,1);
    ev(0,1,1,1,1,0,32'h77,1,1);
    ev(0,0,1,1,1,0,32'h77,1,1);
    ev(0,0,0,1,1,0,32'h77,1,1);
    ev(0,0,0,0,1,0,32'h3C,1,1);
    ev(0,0,0,0,0,0,0,1,1);
    idle(4);
    // mixed pseudo-random traffic against the model
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 99);
      ev(r < 3, r >= 3 && r < 6, r >= 6 && r < 9, r >= 9 && r < 13,
         r >= 13 && r < 55, 2'($urandom_range(0,3)), $urandom,
         r >= 55 && r < 65, r >= 60);
    end
    idle(10);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule